// File: doc/BRIEF.md
# Print-Line Row Buffer with Read-Back Sequencer

This block collects one print line, sent as 36-bit words over a channel-style write path, into a 24-word row buffer. Each of the twelve punch rows takes two consecutive words. Word pair 0-1 holds row 9, and the rows continue in the order 9, 8, 7, 6, 5, 4, 3, 2, 1, 0, 11, 12, so row 12 sits in words 22-23. A start command carries two mode bits. The binary bit makes the line begin at row 1 (word 16) instead of row 9. The echo bit turns on read-back, which is used to verify check printing. In read-back mode the block merges generated words into the incoming stream in a fixed order, and the host reads them from a read-back output port.

A small controller sequences each line through four states: initialise, print data, read-back data and end. A programmable down-counter times every step. The controller flags a sticky I/O check when a word it expects has not arrived, and it pulses end-of-line when the line completes. If the channel is still connected when the end delay runs out, the next line starts automatically. Otherwise the block goes idle. The printing mechanism reads the finished line through a separate combinational read port.

Top module: `lp_row_echo`

## Requirements
- R1: After synchronous reset, `wr_ready_o`, `rd_valid_o`, `eol_o` and `io_check_o` are low, and every line-buffer word reads zero.
- R2: A start is accepted only while the block is idle. While a line is in progress, `start_i` raises `start_stall_o` in the same cycle, and the new modes are ignored: the current line finishes with its own word count and read-back count.
- R3: In normal mode (binary bit 0, echo bit 0), the k-th accepted word is stored at buffer word k. `eol_o` pulses when the word stored at word 23 is accepted. No word is accepted after that, and the port `line_raddr_i`/`line_rdata_o` returns the stored words.
- R4: In binary print mode, the first accepted word goes to word 16 (row 1). The line ends after the word at word 17, which is two words in total.
- R5: In print mode, a word accepted with `wr_eor_i` high is stored and then ends the line, with an `eol_o` pulse.
- R6: In read-back mode, the 46 steps run as follows: print words 0-17, read-back 8+4 (two words), print words 18-19, read-back 8+3, print words 20-21, read-back of row 9, print words 22-23, then read-back of rows 8 down to 1. The read-back words number 22 in total. Read-back words 4-21 equal buffer words 0-17.
- R7: Read-back words 0-1 are the bitwise AND of buffer words 2-3 (row 8) with words 10-11 (row 4). Read-back words 2-3 are the AND of words 2-3 with words 12-13 (row 3).
- R8: `wr_ready_o` first rises `dly_line_i` cycles after the edge that accepts a start. Consecutive read-back words that have no print step between them come `dly_short_i` cycles apart. After a print step the delay is `dly_short_i` when the updated word pointer is odd and `dly_long_i` when it is even.
- R9: When a print step is serviced with no word held, `io_check_o` is set and stays set until reset.
- R10: When the end delay expires with `chan_conn_i` high, a new line starts in the same modes, with the buffer cleared and `wr_ready_o` raised again. With `chan_conn_i` low the block goes idle, and the next start is accepted without a stall.
- R11: In print mode, a print step serviced while `chan_conn_i` is low ends the line, with an `eol_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-line command |
| start_bin_i | input | 1 | Binary mode bit sampled with start |
| start_echo_i | input | 1 | Read-back mode bit sampled with start |
| start_stall_o | output | 1 | Start refused because a line is in progress |
| dly_short_i | input | 16 | Short step delay in cycles |
| dly_long_i | input | 16 | Long step delay in cycles |
| dly_line_i | input | 16 | Delay after start and after line end |
| wr_valid_i | input | 1 | Write word valid |
| wr_ready_o | output | 1 | Block wants a print word |
| wr_data_i | input | 36 | Write word |
| wr_eor_i | input | 1 | End of record, with the write word |
| chan_conn_i | input | 1 | Channel still connected |
| rd_valid_o | output | 1 | Read-back word valid, one cycle |
| rd_data_o | output | 36 | Read-back word |
| eol_o | output | 1 | End-of-line pulse |
| io_check_o | output | 1 | Sticky missing-word flag |
| line_raddr_i | input | 5 | Line buffer read address |
| line_rdata_o | output | 36 | Line buffer read data (zero past word 23) |

## Verification
A stuck or skipped step pointer shows up at once in read-back mode. The read-back words arrive in the wrong order or with the wrong contents, and the count of 22 at `eol_o` is missed, so the fault is visible within a single line. A wrong end limit or start word changes how many words `wr_ready_o` lets through before `eol_o`. A stale buffer shows up on the line read port before the next line begins. Delay or state-sequencing faults move the first `wr_ready_o` rise or the spacing between read-back pulses by whole cycles, and the bench measures both exactly.

// File: rtl/lp_echo_pkg.sv
package lp_echo_pkg;

    localparam int WORD_W     = 36;
    localparam int LINE_WORDS = 24;
    localparam int ECHO_WORDS = 22;
    localparam int STEPS      = LINE_WORDS + ECHO_WORDS;
    localparam int DLY_W      = 16;
    localparam int PTR_W      = 6;
    localparam int ADDR_W     = $clog2(LINE_WORDS);

    // word offsets of the rows the read-back logic combines
    localparam int ROW8_W = 2;
    localparam int ROW4_W = 10;
    localparam int ROW3_W = 12;
    localparam int ROW1_W = 16;
    localparam int COPY_OFS = 4;   // read-back words from here on copy the buffer

    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_PRINT = 2'd1,
        ST_ECHO  = 2'd2,
        ST_END   = 2'd3
    } lp_state_e;

    typedef struct packed {
        logic bin;
        logic echo;
    } lp_mode_t;

    typedef struct packed {
        logic                is_echo;
        logic [ADDR_W-1:0]   idx;
    } step_map_t;

    // read-back step order: print words and generated words interleaved
    function automatic step_map_t step_map(input logic [PTR_W-1:0] s);
        step_map_t m;
        m.is_echo = 1'b0;
        m.idx     = '0;
        if (s < 6'd18) begin
            m.idx = ADDR_W'(s);
        end else if (s < 6'd20) begin
            m.is_echo = 1'b1; m.idx = ADDR_W'(s - 6'd18);
        end else if (s < 6'd22) begin
            m.idx = ADDR_W'(s - 6'd2);
        end else if (s < 6'd24) begin
            m.is_echo = 1'b1; m.idx = ADDR_W'(s - 6'd20);
        end else if (s < 6'd26) begin
            m.idx = ADDR_W'(s - 6'd4);
        end else if (s < 6'd28) begin
            m.is_echo = 1'b1; m.idx = ADDR_W'(s - 6'd22);
        end else if (s < 6'd30) begin
            m.idx = ADDR_W'(s - 6'd6);
        end else begin
            m.is_echo = 1'b1; m.idx = ADDR_W'(s - 6'd24);
        end
        return m;
    endfunction

endpackage

// File: rtl/lp_delay_timer.sv
module lp_delay_timer #(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [DLY_W-1:0] value_i,
    output logic             expire_o,
    output logic             busy_o
);
    logic [DLY_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= (value_i == '0) ? DLY_W'(1) : value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - DLY_W'(1);
        end
    end

    assign expire_o = (cnt_q == DLY_W'(1));
    assign busy_o   = (cnt_q != '0);
endmodule

// File: rtl/lp_row_store.sv
module lp_row_store
    import lp_echo_pkg::*;
#(
    parameter int W     = WORD_W,
    parameter int DEPTH = LINE_WORDS,
    parameter int AW    = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o,
    input  logic [AW-1:0] echo_idx_i,
    output logic [W-1:0]  echo_o
);
    localparam int CMB_WORDS = 4;

    logic [W-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || clr_i) begin
                q <= '0;
            end else if (we_i && (waddr_i == AW'(g))) begin
                q <= wdata_i;
            end
        end
        assign words[g] = q;
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (raddr_i == AW'(i)) rdata_o = words[i];
        end
    end

    // read-back words are formed from the live rows 9..1, which no longer
    // change once the first read-back step is reached
    always_comb begin
        echo_o = '0;
        for (int i = 0; i < 2; i++) begin
            if (echo_idx_i == AW'(i))
                echo_o = words[ROW8_W + i] & words[ROW4_W + i];
            if (echo_idx_i == AW'(i + 2))
                echo_o = words[ROW8_W + i] & words[ROW3_W + i];
        end
        for (int i = 0; i < ECHO_WORDS - CMB_WORDS; i++) begin
            if (echo_idx_i == AW'(i + COPY_OFS)) echo_o = words[i];
        end
    end
endmodule

// File: rtl/lp_seq_ctrl.sv
module lp_seq_ctrl
    import lp_echo_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int DW  = DLY_W,
    parameter int PW  = PTR_W,
    parameter int AW  = ADDR_W,
    parameter int NW  = LINE_WORDS,
    parameter int NS  = STEPS,
    parameter int BIN_START = ROW1_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          start_bin_i,
    input  logic          start_echo_i,
    output logic          start_stall_o,
    input  logic [DW-1:0] dly_short_i,
    input  logic [DW-1:0] dly_long_i,
    input  logic [DW-1:0] dly_line_i,
    input  logic          wr_valid_i,
    output logic          wr_ready_o,
    input  logic [W-1:0]  wr_data_i,
    input  logic          wr_eor_i,
    input  logic          chan_conn_i,
    output logic          rd_valid_o,
    output logic [W-1:0]  rd_data_o,
    output logic          eol_o,
    output logic          io_check_o,
    input  logic          tmr_expire_i,
    input  logic          tmr_busy_i,
    output logic          tmr_load_o,
    output logic [DW-1:0] tmr_val_o,
    output logic          st_clr_o,
    output logic          st_we_o,
    output logic [AW-1:0] st_waddr_o,
    output logic [W-1:0]  st_wdata_o,
    output logic [AW-1:0] echo_idx_o,
    input  logic [W-1:0]  echo_word_i
);
    localparam logic [PW-1:0] BIN_LAST  = PW'(BIN_START + 1);
    localparam logic [PW-1:0] NORM_LAST = PW'(NW - 1);

    lp_state_e      state_q, state_d;
    lp_mode_t       mode_q, mode_d;
    logic [PW-1:0]  ptr_q, ptr_d;
    logic [W-1:0]   hold_q, hold_d;
    logic           hold_v_q, hold_v_d;
    logic           ioc_q, ioc_d;
    logic           eol_q, eol_d;
    logic           rdv_q, rdv_d;
    logic [W-1:0]   rdd_q, rdd_d;

    step_map_t      cur;
    logic           accept, start_go, line_done, have_word;
    logic [PW-1:0]  lim;

    assign cur        = step_map(ptr_q);
    assign echo_idx_o = cur.idx;
    assign lim        = mode_q.bin ? BIN_LAST : NORM_LAST;

    assign start_stall_o = start_i && tmr_busy_i;
    assign start_go      = start_i && !tmr_busy_i;

    assign wr_ready_o = tmr_busy_i && !hold_v_q &&
                        ((state_q == ST_PRINT) ||
                         ((state_q == ST_ECHO) && (ptr_q < PW'(NS)) && !cur.is_echo));
    assign accept    = wr_valid_i && wr_ready_o;
    assign have_word = hold_v_q || accept;

    always_comb begin
        state_d    = state_q;
        mode_d     = mode_q;
        ptr_d      = ptr_q;
        hold_d     = hold_q;
        hold_v_d   = hold_v_q;
        ioc_d      = ioc_q;
        eol_d      = 1'b0;
        rdv_d      = 1'b0;
        rdd_d      = rdd_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = dly_line_i;
        st_clr_o   = 1'b0;
        st_we_o    = 1'b0;
        st_waddr_o = AW'(ptr_q);
        st_wdata_o = wr_data_i;
        line_done  = 1'b0;

        if (start_go) begin
            mode_d     = '{bin: start_bin_i, echo: start_echo_i};
            state_d    = ST_INIT;
            tmr_load_o = 1'b1;
            tmr_val_o  = dly_line_i;
        end else if (tmr_busy_i) begin
            unique case (state_q)
                ST_INIT: if (tmr_expire_i) begin
                    st_clr_o   = 1'b1;
                    ptr_d      = mode_q.bin ? PW'(BIN_START) : '0;
                    state_d    = mode_q.echo ? ST_ECHO : ST_PRINT;
                    hold_d     = '0;
                    hold_v_d   = 1'b0;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = dly_short_i;
                end
                ST_PRINT: begin
                    if (accept) begin
                        st_we_o  = 1'b1;
                        ptr_d    = ptr_q + PW'(1);
                        hold_d   = wr_data_i;
                        hold_v_d = 1'b1;
                        if (wr_eor_i || (ptr_q >= lim)) line_done = 1'b1;
                    end
                    if (tmr_expire_i && !line_done) begin
                        if (!chan_conn_i) begin
                            line_done = 1'b1;
                        end else begin
                            if (!have_word) ioc_d = 1'b1;
                            hold_v_d   = 1'b0;
                            tmr_load_o = 1'b1;
                            tmr_val_o  = ptr_d[0] ? dly_short_i : dly_long_i;
                        end
                    end
                end
                ST_ECHO: begin
                    if (accept) begin
                        hold_d   = wr_data_i;
                        hold_v_d = 1'b1;
                    end
                    if (tmr_expire_i) begin
                        ptr_d = ptr_q + PW'(1);
                        if (cur.is_echo) begin
                            rdv_d = 1'b1;
                            rdd_d = echo_word_i;
                            if (ptr_d >= PW'(NS)) begin
                                line_done = 1'b1;
                            end else begin
                                tmr_load_o = 1'b1;
                                tmr_val_o  = dly_short_i;
                            end
                        end else begin
                            if (!have_word) ioc_d = 1'b1;
                            hold_v_d   = 1'b0;
                            st_we_o    = 1'b1;
                            st_waddr_o = cur.idx;
                            st_wdata_o = accept ? wr_data_i : hold_q;
                            tmr_load_o = 1'b1;
                            tmr_val_o  = ptr_d[0] ? dly_short_i : dly_long_i;
                        end
                    end
                end
                ST_END: if (tmr_expire_i && chan_conn_i) begin
                    state_d    = ST_INIT;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = DW'(1);
                end
                default: ;
            endcase
        end

        if (line_done) begin
            state_d    = ST_END;
            eol_d      = 1'b1;
            tmr_load_o = 1'b1;
            tmr_val_o  = dly_line_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_INIT;
            mode_q   <= '0;
            ptr_q    <= '0;
            hold_q   <= '0;
            hold_v_q <= 1'b0;
            ioc_q    <= 1'b0;
            eol_q    <= 1'b0;
            rdv_q    <= 1'b0;
            rdd_q    <= '0;
        end else begin
            state_q  <= state_d;
            mode_q   <= mode_d;
            ptr_q    <= ptr_d;
            hold_q   <= hold_d;
            hold_v_q <= hold_v_d;
            ioc_q    <= ioc_d;
            eol_q    <= eol_d;
            rdv_q    <= rdv_d;
            rdd_q    <= rdd_d;
        end
    end

    assign rd_valid_o = rdv_q;
    assign rd_data_o  = rdd_q;
    assign eol_o      = eol_q;
    assign io_check_o = ioc_q;
endmodule

// File: rtl/lp_row_echo.sv
module lp_row_echo
    import lp_echo_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int DW = DLY_W,
    parameter int NW = LINE_WORDS
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          start_bin_i,
    input  logic          start_echo_i,
    output logic          start_stall_o,
    input  logic [DW-1:0] dly_short_i,
    input  logic [DW-1:0] dly_long_i,
    input  logic [DW-1:0] dly_line_i,
    input  logic          wr_valid_i,
    output logic          wr_ready_o,
    input  logic [W-1:0]  wr_data_i,
    input  logic          wr_eor_i,
    input  logic          chan_conn_i,
    output logic          rd_valid_o,
    output logic [W-1:0]  rd_data_o,
    output logic          eol_o,
    output logic          io_check_o,
    input  logic [$clog2(NW)-1:0] line_raddr_i,
    output logic [W-1:0]  line_rdata_o
);
    localparam int AW = $clog2(NW);
    localparam int NS = NW + ECHO_WORDS;
    localparam int PW = $clog2(NS + 1);

    logic          tmr_load, tmr_expire, tmr_busy;
    logic [DW-1:0] tmr_val;
    logic          st_clr, st_we;
    logic [AW-1:0] st_waddr, echo_idx;
    logic [W-1:0]  st_wdata, echo_word;

    lp_delay_timer #(.DLY_W(DW)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (tmr_load),
        .value_i  (tmr_val),
        .expire_o (tmr_expire),
        .busy_o   (tmr_busy)
    );

    lp_row_store #(.W(W), .DEPTH(NW), .AW(AW)) store_i (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (st_clr),
        .we_i       (st_we),
        .waddr_i    (st_waddr),
        .wdata_i    (st_wdata),
        .raddr_i    (line_raddr_i),
        .rdata_o    (line_rdata_o),
        .echo_idx_i (echo_idx),
        .echo_o     (echo_word)
    );

    lp_seq_ctrl #(.W(W), .DW(DW), .PW(PW), .AW(AW), .NW(NW), .NS(NS)) ctrl_i (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .start_bin_i   (start_bin_i),
        .start_echo_i  (start_echo_i),
        .start_stall_o (start_stall_o),
        .dly_short_i   (dly_short_i),
        .dly_long_i    (dly_long_i),
        .dly_line_i    (dly_line_i),
        .wr_valid_i    (wr_valid_i),
        .wr_ready_o    (wr_ready_o),
        .wr_data_i     (wr_data_i),
        .wr_eor_i      (wr_eor_i),
        .chan_conn_i   (chan_conn_i),
        .rd_valid_o    (rd_valid_o),
        .rd_data_o     (rd_data_o),
        .eol_o         (eol_o),
        .io_check_o    (io_check_o),
        .tmr_expire_i  (tmr_expire),
        .tmr_busy_i    (tmr_busy),
        .tmr_load_o    (tmr_load),
        .tmr_val_o     (tmr_val),
        .st_clr_o      (st_clr),
        .st_we_o       (st_we),
        .st_waddr_o    (st_waddr),
        .st_wdata_o    (st_wdata),
        .echo_idx_o    (echo_idx),
        .echo_word_i   (echo_word)
    );
endmodule

// File: rtl/lp_row_echo_chk.sv
module lp_row_echo_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic start_echo_i,
    input logic start_stall_o,
    input logic wr_ready_o,
    input logic rd_valid_o,
    input logic eol_o,
    input logic io_check_o
);
    logic [5:0] rd_seen;
    logic       echo_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_seen   <= '0;
            echo_line <= 1'b0;
        end else if (start_i && !start_stall_o) begin
            rd_seen   <= '0;
            echo_line <= start_echo_i;
        end else if (eol_o) begin
            rd_seen   <= '0;
        end else if (rd_valid_o) begin
            rd_seen   <= rd_seen + 6'd1;
        end
    end

    p_start_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !start_stall_o) |=> (!wr_ready_o && !rd_valid_o));

    p_eol_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        eol_o |=> !eol_o);

    p_ioc_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        io_check_o |=> io_check_o);

    p_echo_total_r6: assert property (@(posedge clk) disable iff (rst)
        eol_o |-> ((rd_seen + 6'(rd_valid_o)) == (echo_line ? 6'd22 : 6'd0)));
endmodule

bind lp_row_echo lp_row_echo_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .start_echo_i  (start_echo_i),
    .start_stall_o (start_stall_o),
    .wr_ready_o    (wr_ready_o),
    .rd_valid_o    (rd_valid_o),
    .eol_o         (eol_o),
    .io_check_o    (io_check_o)
);

// File: tb/lp_row_echo_tb_top.sv
`timescale 1ns/1ps
module lp_row_echo_tb_top;
    localparam int DLY_SHORT = 3;
    localparam int DLY_LONG  = 6;
    localparam int DLY_LINE  = 40;

    typedef struct packed {
        logic       bin;
        logic       echo;
        logic [5:0] eor_at;
        logic [7:0] seed;
        logic [5:0] n_words;
        logic [5:0] n_echo;
    } vec_t;

    // bin, echo, eor index (63 = none), seed, words taken, read-back words
    localparam vec_t VEC [6] = '{
        '{1'b0, 1'b0, 6'd63, 8'd1, 6'd24, 6'd0},
        '{1'b1, 1'b0, 6'd63, 8'd2, 6'd2,  6'd0},
        '{1'b0, 1'b0, 6'd6,  8'd3, 6'd7,  6'd0},
        '{1'b0, 1'b1, 6'd63, 8'd4, 6'd24, 6'd22},
        '{1'b1, 1'b1, 6'd63, 8'd5, 6'd8,  6'd22},
        '{1'b0, 1'b0, 6'd0,  8'd6, 6'd1,  6'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, start_bin = 1'b0, start_echo = 1'b0;
    logic        stall;
    logic        wr_valid = 1'b0, wr_ready, wr_eor = 1'b0;
    logic [35:0] wr_data = '0;
    logic        conn = 1'b1;
    logic        rd_valid, eol, ioc;
    logic [35:0] rd_data, line_rdata;
    logic [4:0]  line_raddr = '0;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int feed_cnt = 0, feed_n = 0, eor_at = 63, feed_seed = 0;
    bit feed_en = 1'b0, bench_clr = 1'b0;
    int rd_cnt = 0, eol_cnt = 0;
    logic [35:0] rd_log [32];
    int          rd_t   [32];

    always #2.5 clk = ~clk;

    lp_row_echo dut_i (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .start_bin_i   (start_bin),
        .start_echo_i  (start_echo),
        .start_stall_o (stall),
        .dly_short_i   (16'(DLY_SHORT)),
        .dly_long_i    (16'(DLY_LONG)),
        .dly_line_i    (16'(DLY_LINE)),
        .wr_valid_i    (wr_valid),
        .wr_ready_o    (wr_ready),
        .wr_data_i     (wr_data),
        .wr_eor_i      (wr_eor),
        .chan_conn_i   (conn),
        .rd_valid_o    (rd_valid),
        .rd_data_o     (rd_data),
        .eol_o         (eol),
        .io_check_o    (ioc),
        .line_raddr_i  (line_raddr),
        .line_rdata_o  (line_rdata)
    );

    function automatic logic [35:0] mkword(int seed, int k);
        logic [35:0] a;
        a = 36'h9E3779B97 * 36'(seed * 31 + k + 1);
        return a ^ (36'h5A5A5A5A5 >> (k % 7));
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (bench_clr) begin
            feed_cnt <= 0; rd_cnt <= 0; eol_cnt <= 0;
        end else begin
            if (wr_valid && wr_ready) feed_cnt <= feed_cnt + 1;
            if (eol) eol_cnt <= eol_cnt + 1;
            if (rd_valid && rd_cnt < 32) begin
                rd_log[rd_cnt] <= rd_data;
                rd_t[rd_cnt]   <= cyc;
                rd_cnt         <= rd_cnt + 1;
            end
        end
    end

    // channel-side word feeder
    initial begin
        forever begin
            @(negedge clk);
            wr_valid = feed_en && (feed_cnt < feed_n) && !rst;
            wr_data  = mkword(feed_seed, feed_cnt);
            wr_eor   = (feed_cnt == eor_at);
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic clear_logs();
        @(negedge clk); bench_clr = 1'b1;
        @(negedge clk); bench_clr = 1'b0;
    endtask

    task automatic start_line(input logic b, input logic e);
        @(negedge clk);
        start = 1'b1; start_bin = b; start_echo = e;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_eol(input int lim, output bit got);
        int base = eol_cnt;
        got = 1'b0;
        for (int n = 0; n < lim; n++) begin
            @(negedge clk);
            if (eol_cnt != base) begin got = 1'b1; break; end
        end
    endtask

    task automatic run_vector(input vec_t v);
        logic [35:0] eb [24];
        logic [35:0] ex;
        int          base;
        bit          got;
        string       tag;
        base = v.bin ? 16 : 0;
        tag  = v.echo ? "R6" : (v.eor_at != 63) ? "R5" : v.bin ? "R4" : "R3";
        for (int i = 0; i < 24; i++) eb[i] = '0;
        for (int k = 0; k < int'(v.n_words); k++) eb[base + k] = mkword(int'(v.seed), k);
        feed_seed = int'(v.seed); eor_at = int'(v.eor_at); feed_n = 40;
        clear_logs();
        conn = 1'b1; feed_en = 1'b1;
        start_line(v.bin, v.echo);
        wait_eol(3000, got);
        check(got, {tag, " eol reached"}, got, 1);
        conn = 1'b0; feed_en = 1'b0;
        repeat (DLY_LINE + 5) @(negedge clk);
        check(feed_cnt == int'(v.n_words), {tag, " words accepted"}, feed_cnt, v.n_words);
        check(rd_cnt == int'(v.n_echo), "R6 read-back count", rd_cnt, v.n_echo);
        check(ioc == 1'b0, "R9 no io check on full feed", ioc, 0);
        for (int a = 0; a < 24; a++) begin
            line_raddr = 5'(a); #0.5;
            check(line_rdata == eb[a], "R3 line buffer word", line_rdata, eb[a]);
        end
        if (v.echo) begin
            for (int j = 0; j < 22; j++) begin
                if (j < 2)      ex = eb[2 + j] & eb[10 + j];
                else if (j < 4) ex = eb[j] & eb[10 + j];
                else            ex = eb[j - 4];
                check(rd_log[j] == ex, (j < 4) ? "R7 combined row" : "R6 copied row", rd_log[j], ex);
            end
            for (int j = 6; j < 21; j++)
                check(rd_t[j + 1] - rd_t[j] == DLY_SHORT, "R8 read-back spacing",
                      rd_t[j + 1] - rd_t[j], DLY_SHORT);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        bit got;
        int n;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(wr_ready == 1'b0, "R1 ready after reset", wr_ready, 0);
        check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        check(eol == 1'b0, "R1 eol after reset", eol, 0);
        check(ioc == 1'b0, "R1 io check after reset", ioc, 0);
        line_raddr = 5'd5; #0.5;
        check(line_rdata == '0, "R1 buffer after reset", line_rdata, 0);

        foreach (VEC[i]) run_vector(VEC[i]);

        // R8 start delay, R2 stall while busy
        clear_logs();
        feed_seed = 9; eor_at = 63; feed_n = 40; conn = 1'b1; feed_en = 1'b0;
        start_line(1'b0, 1'b0);
        n = 1;
        while (!wr_ready && n < 200) begin @(negedge clk); n++; end
        check(n == DLY_LINE + 1, "R8 ready after start delay", n, DLY_LINE + 1);
        start = 1'b1; start_bin = 1'b1; start_echo = 1'b1; #0.5;
        check(stall == 1'b1, "R2 stall while busy", stall, 1);
        @(negedge clk); start = 1'b0;
        feed_en = 1'b1;
        wait_eol(3000, got);
        check(got, "R2 line completes", got, 1);
        feed_en = 1'b0;
        check(feed_cnt == 24, "R2 modes unchanged word count", feed_cnt, 24);
        check(rd_cnt == 0, "R2 modes unchanged read-back", rd_cnt, 0);

        // R10 reconnect, R9 missing word, R11 disconnect
        n = 0;
        while (!wr_ready && n < 200) begin @(negedge clk); n++; end
        check(wr_ready == 1'b1, "R10 next line starts while connected", wr_ready, 1);
        line_raddr = 5'd0; #0.5;
        check(line_rdata == '0, "R10 buffer cleared for next line", line_rdata, 0);
        repeat (DLY_SHORT + 3) @(negedge clk);
        check(ioc == 1'b1, "R9 io check on missing word", ioc, 1);
        repeat (DLY_LONG * 2) @(negedge clk);
        check(ioc == 1'b1, "R9 io check sticky", ioc, 1);
        conn = 1'b0;
        wait_eol(50, got);
        check(got, "R11 disconnect ends line", got, 1);
        repeat (DLY_LINE + 5) @(negedge clk);
        check(wr_ready == 1'b0, "R10 idle when disconnected", wr_ready, 0);
        start = 1'b1; start_bin = 1'b0; start_echo = 1'b0; #0.5;
        check(stall == 1'b0, "R10 start accepted when idle", stall, 0);
        @(negedge clk); start = 1'b0;

        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ioc == 1'b0, "R1 io check cleared by reset", ioc, 0);
        check(wr_ready == 1'b0, "R1 ready low after reset", wr_ready, 0);

        summary();
        $finish;
    end
endmodule